// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Fill Controller

This block is a 4 KB direct-mapped cache placed in front of a slower next-level memory. It serves a processor-side port that issues word reads and writes on a 32-bit byte address. The cache holds 1024 frames. Each frame holds one 32-bit word, a 20-bit tag and a valid flag. The hit check is combinational and runs again in every cycle. Its result drives the stall output straight to the requester. The requester keeps its request steady while the stall is high.

When a read misses, a small controller captures the request address and raises a read request to the next level. It holds that request until the memory acknowledges, which may take any number of cycles. It then writes the returned word, the tag and the valid flag into the indexed frame. In the following cycle the lookup hits, so the stall drops without any separate completion signal.

Writes go through to the next level every time. A write that hits also updates the resident word. A write that misses leaves the cache unchanged.

Top module: `dm_cache`

## Requirements
- R1: Reset clears the valid flag of every frame, so the first read of any address after reset misses.
- R2: The address splits into fields as follows. Bits [1:0] select a byte and take no part in the lookup. Bits [11:2] form the frame index. Bits [31:12] form the tag. As an example, 0x000C14B8 uses index 0x12E with tag 0x000C1, and 0x000C14BB hits on the same frame.
- R3: A read is a hit when the indexed frame is valid and its stored tag equals the address tag. On a hit the word appears on `cpu_rdata` in the same cycle, `cpu_stall` stays low and no memory request is made.
- R4: A read miss raises `cpu_stall` in the cycle the request is seen. From the next clock edge, `mem_req` is high with `mem_we`=0 and `mem_addr` equal to the captured request address.
- R5: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay high and unchanged until `mem_ack`, whatever the number of wait cycles. With W wait cycles, a read miss or a write stalls for W+2 clock edges.
- R6: The clock edge that samples `mem_ack` for a read fill writes the returned word, tag and valid flag. In the next cycle the repeated lookup hits, so `cpu_stall` drops and `cpu_rdata` carries the filled word.
- R7: Two addresses with the same index and different tags replace each other. Reading one after the other misses each time.
- R8: Every write is sent to the next level (`mem_we`=1, same address and data). The write stalls until the cycle after `mem_ack`, when `cpu_stall` drops. A write that hits also replaces the resident word, so a later read of that address hits and returns the new value. The requester leaves one idle cycle after each completed access.
- R9: A write that misses does not fill its frame, so a later read of that address misses and fetches the word from the next level.
- R10: With no processor request pending, the controller makes no new memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Word read from the indexed frame |
| cpu_stall | output | 1 | Access not finished; requester must wait |
| mem_req | output | 1 | Request to next-level memory |
| mem_we | output | 1 | Next-level request is a write |
| mem_addr | output | 32 | Next-level request address |
| mem_wdata | output | 32 | Next-level write data |
| mem_ack | input | 1 | Single-cycle completion from next level |
| mem_rdata | input | 32 | Read word from next level, valid with `mem_ack` |

## Verification
The assertions check the memory handshake in every cycle. The request must stay stable until it is acknowledged. A read fill must keep the stall raised, and the stall must drop right after the acknowledge of a fill. A write may complete only after an acknowledged memory write. A read hit must start no request, and nothing may start a request while the processor is idle. Only the bench scenarios can show the stored contents. These include the index and tag split of 0x000C14B8, conflict replacement on a shared index, the value returned after a write hit, no allocation on a write miss, the exact stall length for each wait count, and valid flags cleared by a second reset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2,
      ST_WDONE = 2'd3
   } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
   parameter int WORD_W  = 30,
   parameter int INDEX_W = 10
) (
   input  logic [WORD_W-1:0]         word_addr,
   output logic [INDEX_W-1:0]        index,
   output logic [WORD_W-INDEX_W-1:0] tag
);
   assign index = word_addr[INDEX_W-1:0];
   assign tag   = word_addr[WORD_W-1:INDEX_W];
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int INDEX_W = 10,
   parameter int TAG_W   = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] rd_index,
   output logic [TAG_W-1:0]   rd_tag,
   output logic               rd_valid,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [TAG_W-1:0]   wr_tag
);
   localparam int DEPTH = 1 << INDEX_W;

   logic [TAG_W-1:0] tags [DEPTH];
   logic [DEPTH-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (wr_en) tags[wr_index] <= wr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= '0;
      else if (wr_en) valid_q[wr_index] <= 1'b1;
   end

   assign rd_tag   = tags[rd_index];
   assign rd_valid = valid_q[rd_index];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
   parameter int INDEX_W = 10,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic [INDEX_W-1:0] rd_index,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [DATA_W-1:0]  wr_data
);
   localparam int DEPTH = 1 << INDEX_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_index] <= wr_data;
   end

   assign rd_data = words[rd_index];
endmodule

// File: rtl/dmc_miss_fsm.sv
module dmc_miss_fsm
   import dmc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              hit,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] held_addr,
   output logic [DATA_W-1:0] held_wdata,
   output logic              fill_en,
   output logic              hit_wr_en,
   output logic              wr_done
);
   dmc_state_e state_q, state_d;
   logic       capture;

   always_comb begin
      state_d = state_q;
      capture = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req && cpu_we) begin
               state_d = ST_WRITE;
               capture = 1'b1;
            end else if (cpu_req && !hit) begin
               state_d = ST_FILL;
               capture = 1'b1;
            end
         end
         ST_FILL:  if (mem_ack) state_d = ST_IDLE;
         ST_WRITE: if (mem_ack) state_d = ST_WDONE;
         ST_WDONE: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         held_addr  <= '0;
         held_wdata <= '0;
      end else begin
         state_q <= state_d;
         if (capture) begin
            held_addr  <= cpu_addr;
            held_wdata <= cpu_wdata;
         end
      end
   end

   assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign fill_en   = (state_q == ST_FILL) && mem_ack;
   assign hit_wr_en = (state_q == ST_IDLE) && cpu_req && cpu_we && hit;
   assign wr_done   = (state_q == ST_WDONE);
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int OFFSET_W = $clog2(DATA_W / 8);
   localparam int WORD_W   = ADDR_W - OFFSET_W;
   localparam int TAG_W    = WORD_W - INDEX_W;

   if ((DATA_W % 8) != 0 || ((8 << OFFSET_W) != DATA_W)) begin : g_bad_data_w
      $error("dm_cache: DATA_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_index_w
      $error("dm_cache: INDEX_W leaves no tag bits");
   end

   logic [INDEX_W-1:0] lk_index, fl_index, wr_index;
   logic [TAG_W-1:0]   lk_tag, fl_tag, st_tag;
   logic               st_valid, hit, fill_en, hit_wr_en, wr_done;
   logic [ADDR_W-1:0]  held_addr;
   logic [DATA_W-1:0]  held_wdata, wr_data;

   dmc_addr_split #(.WORD_W(WORD_W), .INDEX_W(INDEX_W)) u_lookup_split (
      .word_addr(cpu_addr[ADDR_W-1:OFFSET_W]), .index(lk_index), .tag(lk_tag));

   dmc_addr_split #(.WORD_W(WORD_W), .INDEX_W(INDEX_W)) u_fill_split (
      .word_addr(held_addr[ADDR_W-1:OFFSET_W]), .index(fl_index), .tag(fl_tag));

   dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_index(lk_index), .rd_tag(st_tag), .rd_valid(st_valid),
      .wr_en(fill_en), .wr_index(fl_index), .wr_tag(fl_tag));

   assign wr_index = fill_en ? fl_index  : lk_index;
   assign wr_data  = fill_en ? mem_rdata : cpu_wdata;

   dmc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
      .clk(clk), .rd_index(lk_index), .rd_data(cpu_rdata),
      .wr_en(fill_en || hit_wr_en), .wr_index(wr_index), .wr_data(wr_data));

   assign hit = st_valid && (st_tag == lk_tag);

   dmc_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .hit(hit), .mem_ack(mem_ack),
      .mem_req(mem_req), .mem_we(mem_we),
      .held_addr(held_addr), .held_wdata(held_wdata),
      .fill_en(fill_en), .hit_wr_en(hit_wr_en), .wr_done(wr_done));

   assign mem_addr  = held_addr;
   assign mem_wdata = held_wdata;
   assign cpu_stall = cpu_req && (cpu_we ? !wr_done : !hit);
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_stall,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

   a_r4_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && cpu_req && !cpu_we |-> cpu_stall);

   a_r6_stall_drops: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_we && cpu_req && !cpu_we
      |=> !cpu_req || cpu_we || !$stable(cpu_addr) || !cpu_stall);

   a_r8_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_we && !cpu_stall |-> $past(mem_req && mem_ack && mem_we));

   a_r3_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !cpu_stall && !mem_req |=> !mem_req);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req && !mem_req |=> !mem_req);
endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack));

// File: tb/dm_cache_bench.sv
`timescale 1ns/1ps
module dm_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_req, cpu_we, cpu_stall, mem_req, mem_we, mem_ack;
   logic [31:0] cpu_addr, cpu_wdata, cpu_rdata, mem_addr, mem_wdata, mem_rdata;

   int checks = 0, errors = 0, lat = 0, wcnt = 0, ntx = 0;
   logic        last_we;
   logic [31:0] last_addr, last_wdata;
   logic [31:0] wmem [logic [31:0]];

   always #2.5 clk = ~clk;

   dm_cache u_dm_cache (.*);

   function automatic logic [31:0] model(input logic [31:0] a);
      logic [31:0] w = {a[31:2], 2'b00};
      if (wmem.exists(w)) return wmem[w];
      return w ^ 32'h5A5A_1234;
   endfunction

   // next-level memory: acknowledges after lat wait cycles
   initial begin
      mem_ack = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (wcnt == lat) begin
               wcnt = 0; ntx++;
               last_we = mem_we; last_addr = mem_addr; last_wdata = mem_wdata;
               if (mem_we) wmem[{mem_addr[31:2], 2'b00}] = mem_wdata;
               mem_rdata = model(mem_addr);
               mem_ack = 1'b1;
            end else wcnt++;
         end
      end
   end

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     input int l, output int cyc, output logic [31:0] rd);
      lat = l; cyc = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      #1;
      while (cpu_stall && cyc < 1000) begin
         @(negedge clk); #1; cyc++;
      end
      rd = cpu_rdata;
      cpu_req = 1'b0; cpu_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_miss;
      int c; logic [31:0] d;
      op(1'b0, 32'h000C_14B8, '0, 3, c, d);
      check("R1 first read after reset stall edges", c, 5);
      check("R5 stall edges with 3 waits", c, 5);
      check("R4 miss address", last_addr, 32'h000C_14B8);
      check("R4 miss is a read", {31'b0, last_we}, 0);
      check("R6 filled word", d, model(32'h000C_14B8));
   endtask

   task automatic t_hit_offset;
      int c, n; logic [31:0] d;
      n = ntx;
      op(1'b0, 32'h000C_14BB, '0, 0, c, d);
      check("R2 offset bits ignored, hits", c, 0);
      check("R3 hit data", d, model(32'h000C_14B8));
      check("R3 no memory request on hit", ntx, n);
   endtask

   task automatic t_conflict;
      int c; logic [31:0] d;
      op(1'b0, 32'h000C_24B8, '0, 1, c, d);
      check("R7 same index 0x12E new tag misses", c, 3);
      check("R7 new word", d, model(32'h000C_24B8));
      op(1'b0, 32'h000C_14B8, '0, 0, c, d);
      check("R7 old tag evicted, misses", c, 2);
      check("R2 tag 0x000C1 refilled", d, model(32'h000C_14B8));
   endtask

   task automatic t_latencies;
      int c; logic [31:0] d;
      for (int l = 0; l < 6; l++) begin
         op(1'b0, 32'h0004_0000 + 32'(l * 4), '0, l, c, d);
         check("R5 stall edges = waits+2", c, l + 2);
         check("R6 fill data", d, model(32'h0004_0000 + 32'(l * 4)));
      end
      for (int l = 0; l < 6; l++) begin
         op(1'b0, 32'h0004_0000 + 32'(l * 4), '0, 4, c, d);
         check("R3 re-read hits", c, 0);
      end
   endtask

   task automatic t_write_hit;
      int c, n; logic [31:0] d;
      op(1'b1, 32'h000C_14B8, 32'hDEAD_BEEF, 2, c, d);
      check("R8 write stall edges", c, 4);
      check("R8 write sent through", {31'b0, last_we}, 1);
      check("R8 write address", last_addr, 32'h000C_14B8);
      check("R8 write data", last_wdata, 32'hDEAD_BEEF);
      n = ntx;
      op(1'b0, 32'h000C_14B8, '0, 0, c, d);
      check("R8 read after write hit hits", c, 0);
      check("R8 updated word", d, 32'hDEAD_BEEF);
      check("R8 no memory request", ntx, n);
   endtask

   task automatic t_write_miss;
      int c, n; logic [31:0] d;
      op(1'b1, 32'h0000_7000, 32'h1234_5678, 1, c, d);
      check("R8 write miss stall edges", c, 3);
      n = ntx;
      op(1'b0, 32'h0000_7000, '0, 0, c, d);
      check("R9 no allocate: read misses", c, 2);
      check("R9 fetched written word", d, 32'h1234_5678);
      check("R9 one memory request", ntx, n + 1);
   endtask

   task automatic t_idle;
      int n = ntx; int seen = 0;
      repeat (10) begin @(negedge clk); if (mem_req) seen++; end
      check("R10 no request while idle", seen, 0);
      check("R10 no transactions while idle", ntx, n);
   endtask

   task automatic t_reset_clears;
      int c; logic [31:0] d;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      op(1'b0, 32'h0004_0004, '0, 0, c, d);
      check("R1 reset cleared valid, read misses", c, 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      check("R1 no stall in reset", {31'b0, cpu_stall}, 0);
      check("R10 no request in reset", {31'b0, mem_req}, 0);
      rst_n = 1'b1;
      t_reset_miss();
      t_hit_offset();
      t_conflict();
      t_latencies();
      t_write_hit();
      t_write_miss();
      t_idle();
      t_reset_clears();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule